// File: doc/BRIEF.md
# Bootloader Command Frame Receiver with CRC-8 Reply

This block sits on the device side of a half-duplex serial link, between a byte-level receiver and a byte-level transmitter. It takes incoming bytes over a valid/ready stream and assembles them into 8-byte command frames. To do so it hunts for the sync byte, checks the target address and verifies a CRC-8 trailer. When a frame passes all checks, the block pulses a command strobe carrying the command code and its 32-bit argument.

In the cycle of that strobe, the attached logic supplies a status byte and a 32-bit result. The block then sends an 8-byte answer with no further request needed. The answer holds the sync byte, the host address, the status, the result most-significant byte first, and a CRC-8 it computes itself. While the answer is being sent, the receive side refuses bytes, so a command can never overlap a reply. A frame with a bad checksum or a foreign address is discarded without a word. A frame left half-finished is abandoned after a parameterised idle time.

Top module: `boot_frame_link`

## Requirements
- R1: While waiting for a frame start, any received byte other than 0x55 is discarded, and the parser keeps waiting for 0x55.
- R2: A command frame is laid out as follows: byte 0 is 0x55, byte 1 is the address, byte 2 is the command code, bytes 3..6 are the 32-bit value most-significant byte first, and byte 7 is the CRC. An accepted frame raises `cmd_valid` for exactly one cycle, with `cmd_code` and `cmd_value` holding the decoded fields. Any 0x55 inside bytes 1..7 is treated as data.
- R3: The CRC-8 uses polynomial 0x07 with initial value 0. It is computed MSB-first over bytes 0..6, one byte at a time: XOR the byte in, then shift left 8 times, XORing 0x07 after each shift that pushed out a 1. A frame whose byte 7 differs from this value produces no `cmd_valid` and no reply.
- R4: A frame whose byte 1 differs from `DEV_ADDR` (default 1) produces no `cmd_valid` and no reply, even when its CRC is correct.
- R5: The reply is laid out as follows: 0x55, `HOST_ADDR` (default 255), `rsp_status`, then `rsp_value` most-significant byte first, then the CRC-8 of R3 computed over those first 7 bytes. `rsp_status` and `rsp_value` are sampled in the cycle `cmd_valid` is high.
- R6: `tx_valid` rises in the cycle right after the `cmd_valid` pulse.
- R7: If a frame has started and no byte is accepted for `TIMEOUT` cycles, the partial frame is discarded and the parser waits for 0x55 again.
- R8: `rx_ready` is low from the `cmd_valid` cycle until the last reply byte has been accepted.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` hold their values.
- R10: After reset, `rx_ready` is 1, and `tx_valid` and `cmd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte present |
| rx_ready | output | 1 | Block takes the received byte |
| tx_data | output | 8 | Reply byte |
| tx_valid | output | 1 | Reply byte present |
| tx_ready | input | 1 | Transmitter takes the reply byte |
| cmd_valid | output | 1 | One-cycle strobe for an accepted command |
| cmd_code | output | 8 | Command code of the accepted frame |
| cmd_value | output | 32 | 32-bit argument of the accepted frame |
| rsp_status | input | 8 | Status byte for the reply, sampled with cmd_valid |
| rsp_value | input | 32 | Result value for the reply, sampled with cmd_valid |

## Verification
The bench puts non-sync noise ahead of a frame. A design that framed from any byte would then emit wrong commands. It also sends a value made only of 0x55 bytes, which catches a parser that resyncs in mid-frame. Frames with a flipped CRC bit or a foreign address must vanish, and a good frame right after each one must still decode. A design that kept stale state would misframe that good frame. A stall longer than the timeout splits one frame. A second frame sent into a reply in progress, under an irregular `tx_ready`, exposes a receiver that accepts bytes early or lets reply bytes slip while stalled.

// File: rtl/bfl_pkg.sv
package bfl_pkg;
  localparam logic [7:0] SYNC_BYTE = 8'h55;
  localparam logic [7:0] CRC_POLY  = 8'h07;
  localparam int FRAME_BYTES = 8;
  localparam int IDX_W = $clog2(FRAME_BYTES);

  // One byte step of the CRC-8: fold the byte in, then eight shifts.
  function automatic logic [7:0] crc8_byte(input logic [7:0] crc_in,
                                           input logic [7:0] data);
    logic [7:0] c;
    c = crc_in ^ data;
    for (int i = 0; i < 8; i++) begin
      c = c[7] ? ((c << 1) ^ CRC_POLY) : (c << 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/bfl_rx_parser.sv
module bfl_rx_parser
  import bfl_pkg::*;
#(
  parameter logic [7:0] DEV_ADDR = 8'h01,
  parameter int TIMEOUT = 10000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  rx_data,
  input  logic        rx_valid,
  input  logic        hold,
  output logic        rx_ready,
  output logic        cmd_valid,
  output logic [7:0]  cmd_code,
  output logic [31:0] cmd_value
);
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);

  logic [IDX_W-1:0] idx_q;
  logic [7:0]       crc_q, addr_q, code_q;
  logic [31:0]      val_q;
  logic [TW-1:0]    idle_q;

  // Named events for the assertions.
  logic byte_accept, sync_miss, frame_done, crc_match, addr_match, timeout_hit;

  assign rx_ready    = !hold;
  assign byte_accept = rx_valid && rx_ready;
  assign sync_miss   = byte_accept && (idx_q == '0) && (rx_data != SYNC_BYTE);
  assign frame_done  = byte_accept && (idx_q == LAST_IDX);
  assign crc_match   = (rx_data == crc_q);
  assign addr_match  = (addr_q == DEV_ADDR);
  assign timeout_hit = (idx_q != '0) && !byte_accept && (idle_q >= TW'(TIMEOUT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q     <= '0;
      crc_q     <= '0;
      addr_q    <= '0;
      code_q    <= '0;
      val_q     <= '0;
      idle_q    <= '0;
      cmd_valid <= 1'b0;
    end else begin
      cmd_valid <= frame_done && crc_match && addr_match;
      if (byte_accept) begin
        idle_q <= '0;
        if (idx_q == '0) begin
          if (rx_data == SYNC_BYTE) begin
            crc_q <= crc8_byte(8'h00, rx_data);
            idx_q <= IDX_W'(1);
          end
        end else if (idx_q == LAST_IDX) begin
          idx_q <= '0;
        end else begin
          crc_q <= crc8_byte(crc_q, rx_data);
          idx_q <= idx_q + IDX_W'(1);
          if (idx_q == IDX_W'(1)) addr_q <= rx_data;
          else if (idx_q == IDX_W'(2)) code_q <= rx_data;
          else val_q <= {val_q[23:0], rx_data};
        end
      end else if (timeout_hit) begin
        idx_q  <= '0;
        idle_q <= '0;
      end else if (idx_q != '0) begin
        idle_q <= idle_q + TW'(1);
      end
    end
  end

  assign cmd_code  = code_q;
  assign cmd_value = val_q;

  a_r1_sync_hunt: assert property (@(posedge clk) disable iff (!rst_n)
    sync_miss |=> (idx_q == '0));
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  a_r3_bad_crc_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !crc_match) |=> !cmd_valid);
  a_r4_foreign_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !addr_match) |=> !cmd_valid);
  a_r7_timeout_bound: assert property (@(posedge clk) disable iff (!rst_n)
    idle_q <= TW'(TIMEOUT));
  a_r7_timeout_reset: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_hit |=> (idx_q == '0));
endmodule

// File: rtl/bfl_tx_builder.sv
module bfl_tx_builder
  import bfl_pkg::*;
#(
  parameter logic [7:0] HOST_ADDR = 8'hFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [7:0]  status,
  input  logic [31:0] value,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic        busy
);
  localparam int BODY_W = 8 * (FRAME_BYTES - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);

  logic             active_q;
  logic [IDX_W-1:0] idx_q;
  logic [BODY_W-1:0] body_q;
  logic [7:0]       crc_q;
  logic             byte_sent, on_trailer;

  assign on_trailer = (idx_q == LAST_IDX);
  assign tx_valid   = active_q;
  assign tx_data    = on_trailer ? crc_q : body_q[BODY_W-1 -: 8];
  assign byte_sent  = active_q && tx_ready;
  assign busy       = active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      body_q   <= '0;
      crc_q    <= '0;
    end else if (load && !active_q) begin
      active_q <= 1'b1;
      idx_q    <= '0;
      body_q   <= {SYNC_BYTE, HOST_ADDR, status, value};
      crc_q    <= 8'h00;
    end else if (byte_sent) begin
      if (on_trailer) begin
        active_q <= 1'b0;
        idx_q    <= '0;
      end else begin
        crc_q  <= crc8_byte(crc_q, tx_data);
        body_q <= body_q << 8;
        idx_q  <= idx_q + IDX_W'(1);
      end
    end
  end

  a_r9_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> tx_valid);
  a_r9_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> $stable(tx_data));
  a_r5_starts_with_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !active_q) |=> (tx_data == SYNC_BYTE));
endmodule

// File: rtl/boot_frame_link.sv
module boot_frame_link
  import bfl_pkg::*;
#(
  parameter logic [7:0] DEV_ADDR  = 8'h01,
  parameter logic [7:0] HOST_ADDR = 8'hFF,
  parameter int TIMEOUT = 10000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  rx_data,
  input  logic        rx_valid,
  output logic        rx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic        cmd_valid,
  output logic [7:0]  cmd_code,
  output logic [31:0] cmd_value,
  input  logic [7:0]  rsp_status,
  input  logic [31:0] rsp_value
);
  logic tx_busy, rx_hold;

  assign rx_hold = cmd_valid || tx_busy;

  bfl_rx_parser #(.DEV_ADDR(DEV_ADDR), .TIMEOUT(TIMEOUT)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .hold(rx_hold), .rx_ready(rx_ready), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_value(cmd_value)
  );

  bfl_tx_builder #(.HOST_ADDR(HOST_ADDR)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(cmd_valid), .status(rsp_status),
    .value(rsp_value), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .busy(tx_busy)
  );

  a_r6_reply_follows: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> tx_valid);
  a_r8_rx_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid || cmd_valid) |-> !rx_ready);
endmodule

// File: tb/tb_boot_frame_link.sv
module tb_boot_frame_link;
  localparam int TMO = 40;

  logic clk = 0, rst_n = 0;
  logic [7:0] rx_data = 0;
  logic rx_valid = 0, tx_ready = 1;
  logic rx_ready, tx_valid, cmd_valid;
  logic [7:0] tx_data, cmd_code;
  logic [31:0] cmd_value;
  logic [7:0] rsp_status = 0;
  logic [31:0] rsp_value = 0;

  int checks = 0, errors = 0, cyc = 0, cmds_seen = 0, cmds_exp = 0;
  bit bp_en = 0, done = 0;
  logic [39:0] exp_cmd[$];
  logic [7:0]  exp_tx[$];
  logic prev_stall = 0;
  logic [7:0] prev_data = 0;

  always #2 clk = ~clk;

  boot_frame_link #(.TIMEOUT(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_value(cmd_value), .rsp_status(rsp_status), .rsp_value(rsp_value)
  );

  // Reference CRC: bit-serial long division of the whole 56-bit message.
  function automatic logic [7:0] ref_crc(input logic [55:0] msg);
    logic [7:0] r = 8'h00;
    logic fb;
    for (int k = 55; k >= 0; k--) begin
      fb = r[7] ^ msg[k];
      r = {r[6:0], 1'b0};
      if (fb) r = r ^ 8'h07;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [39:0] act,
                       input logic [39:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    #1 tx_ready = bp_en ? ((cyc % 3) != 0) : 1'b1;
  end

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_valid) begin
        cmds_seen++;
        if (exp_cmd.size() == 0)
          check(0, "R3/R4 unexpected command", {cmd_code, cmd_value}, 40'h0);
        else begin
          logic [39:0] e;
          e = exp_cmd.pop_front();
          check({cmd_code, cmd_value} == e, "R2 command fields", {cmd_code, cmd_value}, e);
        end
      end
      if (tx_valid && rx_ready)
        check(0, "R8 rx_ready high during reply", 40'(rx_ready), 40'h0);
      if (prev_stall)
        check(tx_valid && tx_data == prev_data, "R9 stalled byte held",
              40'(tx_data), 40'(prev_data));
      if (tx_valid && tx_ready) begin
        if (exp_tx.size() == 0)
          check(0, "R5 unexpected reply byte", 40'(tx_data), 40'h0);
        else begin
          logic [7:0] eb;
          eb = exp_tx.pop_front();
          check(tx_data == eb, "R5 reply byte", 40'(tx_data), 40'(eb));
        end
      end
      prev_stall = tx_valid && !tx_ready;
      prev_data  = tx_data;
    end
  end

  // R6: reply must start the cycle after the strobe.
  always @(negedge clk) begin
    if (rst_n && cmd_valid) begin
      @(negedge clk);
      check(tx_valid, "R6 reply immediate", 40'(tx_valid), 40'h1);
    end
  end

  task automatic send_byte(input logic [7:0] b);
    rx_data = b;
    rx_valid = 1;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic send_frame(input logic [7:0] addr, input logic [7:0] code,
                            input logic [31:0] val, input bit bad_crc,
                            input bit expect_ok, input logic [7:0] st,
                            input logic [31:0] rv);
    logic [55:0] body, rep;
    logic [7:0] c;
    while (!rx_ready || tx_valid || cmd_valid) @(negedge clk);
    rsp_status = st;
    rsp_value  = rv;
    body = {8'h55, addr, code, val};
    c = ref_crc(body) ^ (bad_crc ? 8'h01 : 8'h00);
    if (expect_ok) begin
      cmds_exp++;
      exp_cmd.push_back({code, val});
      rep = {8'h55, 8'hFF, st, rv};
      for (int i = 6; i >= 0; i--) exp_tx.push_back(rep[i*8 +: 8]);
      exp_tx.push_back(ref_crc(rep));
    end
    for (int i = 6; i >= 0; i--) send_byte(body[i*8 +: 8]);
    send_byte(c);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
    while (tx_valid || exp_tx.size() != 0) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    check(rx_ready && !tx_valid && !cmd_valid, "R10 reset state",
          40'({rx_ready, tx_valid, cmd_valid}), 40'b100);

    // R2 / R5 basic frame
    send_frame(8'h01, 8'h12, 32'hDEADBEEF, 0, 1, 8'h00, 32'h01234567);
    settle(4);

    // R1 noise ahead of a frame
    send_byte(8'h00); send_byte(8'hAA); send_byte(8'h13);
    send_frame(8'h01, 8'h34, 32'h00C0FFEE, 0, 1, 8'h7F, 32'hCAFEF00D);
    settle(4);

    // R3 corrupted CRC, then good frame
    send_frame(8'h01, 8'h40, 32'h11223344, 1, 0, 8'h00, 32'h0);
    settle(20);
    check(cmds_seen == cmds_exp, "R3 bad CRC dropped", 40'(cmds_seen), 40'(cmds_exp));
    send_frame(8'h01, 8'h41, 32'h55667788, 0, 1, 8'h01, 32'hFFFFFFFF);
    settle(4);

    // R4 foreign addresses
    send_frame(8'h02, 8'h50, 32'h0BADBEEF, 0, 0, 8'h00, 32'h0);
    send_frame(8'hFF, 8'h51, 32'h0BADBEEF, 0, 0, 8'h00, 32'h0);
    settle(20);
    check(cmds_seen == cmds_exp, "R4 foreign address dropped", 40'(cmds_seen), 40'(cmds_exp));
    check(!tx_valid, "R4 no reply to foreign frame", 40'(tx_valid), 40'h0);

    // R7 timeout splits a stalled frame
    send_byte(8'h55); send_byte(8'h01); send_byte(8'h60);
    repeat (TMO + 20) @(negedge clk);
    send_frame(8'h01, 8'h61, 32'h00000000, 0, 1, 8'h02, 32'h00000000);
    settle(4);
    check(cmds_seen == cmds_exp, "R7 timeout recovery", 40'(cmds_seen), 40'(cmds_exp));

    // R2 data bytes equal to sync must not resync
    send_frame(8'h01, 8'h55, 32'h55555555, 0, 1, 8'h55, 32'h55555555);
    settle(4);

    // R8 / R9 back-to-back frames under backpressure
    bp_en = 1;
    send_frame(8'h01, 8'h70, 32'h00000001, 0, 1, 8'hA5, 32'h80000000);
    send_frame(8'h01, 8'h71, 32'h80000000, 0, 1, 8'h5A, 32'h00000001);
    settle(4);
    bp_en = 0;
    repeat (10) @(negedge clk);

    check(exp_cmd.size() == 0, "R2 all commands seen", 40'(exp_cmd.size()), 40'h0);
    check(exp_tx.size() == 0, "R5 all reply bytes seen", 40'(exp_tx.size()), 40'h0);
    check(cmds_seen == cmds_exp, "R3 command count", 40'(cmds_seen), 40'(cmds_exp));
    finish_run();
  end
endmodule